// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Shared Prescalers

This block produces several pulse-width-modulated outputs from a small pool of shared timebases. Each timebase is a two-stage prescaler: a 16-bit divider stage followed by an 8-bit cycle counter. It advances on one of two tick strobes. One strobe comes from a fast clock domain. The other comes from a slow 32.768 kHz domain that keeps running in low-power states. A prescaler with divider value D and cycle value C completes one period every (D+1)·(C+1) source ticks.

Each output channel picks one prescaler through a 2-bit selector. It compares that prescaler's cycle count against its own 8-bit duty value. The result then passes through the channel's gate, polarity and open-drain controls. Software programs the block through a byte-wide write port. Divider, cycle and duty writes go into shadow registers, and the live values are replaced only at the end of a period, so a reprogrammed output never produces a glitched period.

Register map (byte addresses): 0x00 control (bit 0 = run), 0x01 source select (bit p for prescaler p), 0x02 gate, 0x03 polarity, 0x04 open-drain (bit c for channel c), 0x05 + c/4 selector group, 0x08 + 4p divider low byte, 0x09 + 4p divider high byte, 0x0A + 4p cycle value, 0x20 + c duty.

Top module: `pwm_multi`

## Requirements
- R1: With run set, a prescaler's cycle count steps once every D+1 of its source ticks and wraps after C, so one period is (D+1)·(C+1) ticks. D is the 16-bit divider assembled from the low byte at 0x08+4p and the high byte at 0x09+4p, and C is the 8-bit cycle value at 0x0A+4p.
- R2: Bit p of register 0x01 makes prescaler p count fast_tick when set and slow_tick when clear.
- R3: Channel c's prescaler selector is bits [(c mod 4)·2 +: 2] of register 0x05 + c/4. Values 0 to 2 pick that prescaler; value 3 holds the channel at its inactive level.
- R4: A running channel is active while its prescaler's cycle count is below its duty value (register 0x20+c). Duty 0 gives a constant inactive output, and a duty of C+1 or more gives a constant active output. pwm_out shows the compare result of the previous clock.
- R5: With its bit in register 0x02 set, a channel is held at its inactive level.
- R6: With its bit in register 0x03 set, a channel's output is inverted. The inactive level is 0 without inversion and 1 with it.
- R7: With its bit in register 0x04 set, pwm_oe of that channel is the inverse of pwm_out, so the pin is only ever driven low. With the bit clear, pwm_oe is 1.
- R8: While bit 0 of register 0x00 is clear, all counters are held at zero, ticks are ignored and every output sits at its inactive level. After the bit is set, counting starts at the beginning of a period.
- R9: Divider, cycle and duty writes made while running take effect only at the next period boundary of the prescaler concerned.
- R10: After reset all registers are zero, pwm_out is all zeros and pwm_oe is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_tick | input | 1 | Count strobe from the fast source |
| slow_tick | input | 1 | Count strobe from the 32.768 kHz source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register byte address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | NUM_CH | Output level per channel |
| pwm_oe | output | NUM_CH | Pin drive enable per channel |

## Verification
The bench sweeps many small prescaler settings, with cycle values from 0 to 5 and divider values from 0 to 2. For each setting it tries duty values from zero up past C+1, so the constant-low, normal and constant-high cases are each exercised. Between settings it rotates the selector of every channel through all four codes, and it varies the source select bits. It also drives the fast and slow strobes at different rates, so that a wrong selector field position or a swapped clock source produces a different waveform. Polarity, gating and open-drain bits are mixed across channels, and a short idle run with ticks applied while stopped separates the run control from the counters.

A long run with a divider above 255 exercises the high byte. A run with writes made partway through a period checks that the new period and duty start exactly at the boundary the bench predicts.

// File: rtl/pwm_multi_pkg.sv
package pwm_multi_pkg;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 8;
  localparam int SEL_W     = 2;
  localparam int PS_STRIDE = 4;
  localparam int SEL_PER_GROUP = 4;

  localparam int A_CTRL  = 'h00;
  localparam int A_SRC   = 'h01;
  localparam int A_GATE  = 'h02;
  localparam int A_POL   = 'h03;
  localparam int A_OD    = 'h04;
  localparam int A_SEL0  = 'h05;
  localparam int A_PS0   = 'h08;
  localparam int A_DUTY0 = 'h20;
endpackage

// File: rtl/pwm_multi_regs.sv
module pwm_multi_regs
  import pwm_multi_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int NUM_PS = 3,
  parameter int DIV_W  = 16,
  parameter int CYC_W  = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [DATA_W-1:0]                   wr_data,
  output logic                                gen_en,
  output logic [NUM_PS-1:0]                   src_fast,
  output logic [NUM_CH-1:0]                   gate_q,
  output logic [NUM_CH-1:0]                   pol_q,
  output logic [NUM_CH-1:0]                   od_q,
  output logic [NUM_CH-1:0][SEL_W-1:0]        sel_q,
  output logic [NUM_PS-1:0][DIV_W-1:0]        div_sh,
  output logic [NUM_PS-1:0][CYC_W-1:0]        cyc_sh,
  output logic [NUM_CH-1:0][CYC_W-1:0]        duty_sh
);
  localparam int HI_W = DIV_W - DATA_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en   <= 1'b0;
      src_fast <= '0;
      gate_q   <= '0;
      pol_q    <= '0;
      od_q     <= '0;
      sel_q    <= '0;
      div_sh   <= '0;
      cyc_sh   <= '0;
      duty_sh  <= '0;
    end else if (wr_en) begin
      if (int'(wr_addr) == A_CTRL) gen_en   <= wr_data[0];
      if (int'(wr_addr) == A_SRC)  src_fast <= wr_data[NUM_PS-1:0];
      if (int'(wr_addr) == A_GATE) gate_q   <= wr_data[NUM_CH-1:0];
      if (int'(wr_addr) == A_POL)  pol_q    <= wr_data[NUM_CH-1:0];
      if (int'(wr_addr) == A_OD)   od_q     <= wr_data[NUM_CH-1:0];
      for (int c = 0; c < NUM_CH; c++) begin
        if (int'(wr_addr) == A_SEL0 + c / SEL_PER_GROUP)
          sel_q[c] <= wr_data[(c % SEL_PER_GROUP)*SEL_W +: SEL_W];
        if (int'(wr_addr) == A_DUTY0 + c)
          duty_sh[c] <= CYC_W'(wr_data);
      end
      for (int p = 0; p < NUM_PS; p++) begin
        if (int'(wr_addr) == A_PS0 + p*PS_STRIDE)
          div_sh[p][DATA_W-1:0] <= wr_data;
        if (int'(wr_addr) == A_PS0 + p*PS_STRIDE + 1)
          div_sh[p][DIV_W-1:DATA_W] <= wr_data[HI_W-1:0];
        if (int'(wr_addr) == A_PS0 + p*PS_STRIDE + 2)
          cyc_sh[p] <= CYC_W'(wr_data);
      end
    end
  end
endmodule

// File: rtl/pwm_multi_prescaler.sv
module pwm_multi_prescaler #(
  parameter int DIV_W = 16,
  parameter int CYC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [DIV_W-1:0] div_sh,
  input  logic [CYC_W-1:0] cyc_sh,
  output logic [CYC_W-1:0] cnt,
  output logic             wrap
);
  logic [DIV_W-1:0] div_cnt, div_act;
  logic [CYC_W-1:0] cyc_act;
  logic             div_end;

  assign div_end = (div_cnt == div_act);
  assign wrap    = run & tick & div_end & (cnt == cyc_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      cnt     <= '0;
      div_act <= '0;
      cyc_act <= '0;
    end else if (!run) begin
      div_cnt <= '0;
      cnt     <= '0;
      div_act <= div_sh;
      cyc_act <= cyc_sh;
    end else if (tick) begin
      if (div_end) begin
        div_cnt <= '0;
        if (cnt == cyc_act) begin
          cnt     <= '0;
          div_act <= div_sh;
          cyc_act <= cyc_sh;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_multi_channel.sv
module pwm_multi_channel
  import pwm_multi_pkg::*;
#(
  parameter int NUM_PS = 3,
  parameter int CYC_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         run,
  input  logic [SEL_W-1:0]             sel,
  input  logic [NUM_PS-1:0][CYC_W-1:0] cnt_all,
  input  logic [NUM_PS-1:0]            wrap_all,
  input  logic [CYC_W-1:0]             duty_sh,
  input  logic                         gate,
  input  logic                         pol,
  input  logic                         od,
  output logic                         pwm_out,
  output logic                         pwm_oe
);
  logic             sel_ok, cur_wrap, raw, level;
  logic [CYC_W-1:0] cur_cnt, duty_act;

  always_comb begin
    sel_ok   = 1'b0;
    cur_cnt  = '0;
    cur_wrap = 1'b0;
    for (int p = 0; p < NUM_PS; p++) begin
      if (int'(sel) == p) begin
        sel_ok   = 1'b1;
        cur_cnt  = cnt_all[p];
        cur_wrap = wrap_all[p];
      end
    end
  end

  assign raw   = run & ~gate & sel_ok & (cur_cnt < duty_act);
  assign level = raw ^ pol;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_act <= '0;
      pwm_out  <= 1'b0;
      pwm_oe   <= 1'b1;
    end else begin
      if (!run || cur_wrap) duty_act <= duty_sh;
      pwm_out <= level;
      pwm_oe  <= od ? ~level : 1'b1;
    end
  end
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_multi_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int NUM_PS = 3,
  parameter int DIV_W  = 16,
  parameter int CYC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fast_tick,
  input  logic              slow_tick,
  input  logic              wr_en,
  input  logic [5:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] pwm_oe
);
  logic                         gen_en;
  logic [NUM_PS-1:0]            src_fast;
  logic [NUM_CH-1:0]            gate_q, pol_q, od_q;
  logic [NUM_CH-1:0][SEL_W-1:0] sel_q;
  logic [NUM_PS-1:0][DIV_W-1:0] div_sh;
  logic [NUM_PS-1:0][CYC_W-1:0] cyc_sh;
  logic [NUM_CH-1:0][CYC_W-1:0] duty_sh;
  logic [NUM_PS-1:0][CYC_W-1:0] cnt_w;
  logic [NUM_PS-1:0]            wrap_w;

  pwm_multi_regs #(
    .NUM_CH(NUM_CH), .NUM_PS(NUM_PS), .DIV_W(DIV_W), .CYC_W(CYC_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gen_en(gen_en), .src_fast(src_fast), .gate_q(gate_q), .pol_q(pol_q),
    .od_q(od_q), .sel_q(sel_q), .div_sh(div_sh), .cyc_sh(cyc_sh),
    .duty_sh(duty_sh)
  );

  for (genvar p = 0; p < NUM_PS; p++) begin : g_ps
    pwm_multi_prescaler #(.DIV_W(DIV_W), .CYC_W(CYC_W)) u_ps (
      .clk(clk), .rst(rst), .run(gen_en),
      .tick(src_fast[p] ? fast_tick : slow_tick),
      .div_sh(div_sh[p]), .cyc_sh(cyc_sh[p]),
      .cnt(cnt_w[p]), .wrap(wrap_w[p])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_multi_channel #(.NUM_PS(NUM_PS), .CYC_W(CYC_W)) u_ch (
      .clk(clk), .rst(rst), .run(gen_en), .sel(sel_q[c]),
      .cnt_all(cnt_w), .wrap_all(wrap_w), .duty_sh(duty_sh[c]),
      .gate(gate_q[c]), .pol(pol_q[c]), .od(od_q[c]),
      .pwm_out(pwm_out[c]), .pwm_oe(pwm_oe[c])
    );
  end
endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk #(
  parameter int NUM_CH = 4,
  parameter int NUM_PS = 3,
  parameter int CYC_W  = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         gen_en,
  input logic [NUM_CH-1:0]            gate_q,
  input logic [NUM_CH-1:0]            pol_q,
  input logic [NUM_CH-1:0]            od_q,
  input logic [NUM_CH-1:0]            pwm_out,
  input logic [NUM_CH-1:0]            pwm_oe,
  input logic [NUM_PS-1:0][CYC_W-1:0] cnt_w,
  input logic [NUM_PS-1:0]            wrap_w
);
  assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pwm_out == '0 && pwm_oe == '1));

  assert_stopped_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(gen_en) |-> (pwm_out == $past(pol_q)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    assert_gated_idle_R5: assert property (@(posedge clk) disable iff (rst)
      $past(gate_q[c]) |-> (pwm_out[c] == $past(pol_q[c])));
    assert_oe_push_pull_R7: assert property (@(posedge clk) disable iff (rst)
      !$past(od_q[c]) |-> pwm_oe[c]);
    assert_oe_low_only_R7: assert property (@(posedge clk) disable iff (rst)
      !pwm_oe[c] |-> pwm_out[c]);
  end

  for (genvar p = 0; p < NUM_PS; p++) begin : g_p
    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
      (cnt_w[p] != $past(cnt_w[p])) |->
        (cnt_w[p] == CYC_W'($past(cnt_w[p]) + 1'b1) || cnt_w[p] == '0));
    assert_wrap_restart_R9: assert property (@(posedge clk) disable iff (rst)
      wrap_w[p] |=> (cnt_w[p] == '0));
  end
endmodule

bind pwm_multi pwm_multi_chk #(
  .NUM_CH(NUM_CH), .NUM_PS(NUM_PS), .CYC_W(CYC_W)
) u_chk (
  .clk(clk), .rst(rst), .gen_en(gen_en), .gate_q(gate_q), .pol_q(pol_q),
  .od_q(od_q), .pwm_out(pwm_out), .pwm_oe(pwm_oe), .cnt_w(cnt_w),
  .wrap_w(wrap_w)
);

// File: tb/pwm_multi_test.sv
`timescale 1ns/1ps
module pwm_multi_test;
  localparam int NCH = 4;
  localparam int NPS = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst, fast_tick, slow_tick, wr_en;
  logic [5:0]     wr_addr;
  logic [7:0]     wr_data;
  logic [NCH-1:0] pwm_out, pwm_oe;

  pwm_multi uut (
    .clk(clk), .rst(rst), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  int vectors = 0, miscompares = 0;
  string req = "R10";

  int mD[NPS], mC[NPS], pD[NPS], pC[NPS], pB[NPS], mn[NPS], mbase[NPS];
  bit pP[NPS], msrc[NPS];
  int mduty[NCH], pduty[NCH], pdB[NCH], msel[NCH];
  bit pdP[NCH], mgate[NCH], mpol[NCH], mod_[NCH];
  bit mrun;

  function automatic bit exp_raw(int ch);
    int p, k, idx;
    if (!mrun || mgate[ch] || msel[ch] >= NPS) return 1'b0;
    p   = msel[ch];
    k   = mn[p] - mbase[p];
    idx = (k / (mD[p] + 1)) % (mC[p] + 1);
    return idx < mduty[ch];
  endfunction

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = 8'(d);
    fast_tick = 1'b0; slow_tick = 1'b0;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push_all();
    int b;
    b = 0; for (int p = 0; p < NPS; p++) b |= int'(msrc[p]) << p;  wr('h01, b);
    b = 0; for (int c = 0; c < NCH; c++) b |= int'(mgate[c]) << c; wr('h02, b);
    b = 0; for (int c = 0; c < NCH; c++) b |= int'(mpol[c]) << c;  wr('h03, b);
    b = 0; for (int c = 0; c < NCH; c++) b |= int'(mod_[c]) << c;  wr('h04, b);
    // R3: selector of channel c at bits (c mod 4)*2 of group register 0x05
    b = 0; for (int c = 0; c < NCH; c++) b |= (msel[c] & 3) << ((c % 4) * 2);
    wr('h05, b);
    for (int p = 0; p < NPS; p++) begin
      wr('h08 + 4*p, mD[p] & 'hff);
      wr('h09 + 4*p, (mD[p] >> 8) & 'hff);
      wr('h0A + 4*p, mC[p]);
    end
    for (int c = 0; c < NCH; c++) wr('h20 + c, mduty[c]);
  endtask

  task automatic set_run(bit on);
    wr('h00, int'(on));
    mrun = on;
    for (int p = 0; p < NPS; p++) begin
      mn[p] = 0; mbase[p] = 0;
      if (pP[p]) begin mD[p] = pD[p]; mC[p] = pC[p]; pP[p] = 1'b0; end
    end
    for (int c = 0; c < NCH; c++)
      if (pdP[c]) begin mduty[c] = pduty[c]; pdP[c] = 1'b0; end
  endtask

  function automatic int next_boundary(int p);
    int per;
    per = (mD[p] + 1) * (mC[p] + 1);
    return mbase[p] + ((mn[p] - mbase[p]) / per + 1) * per;
  endfunction

  // R9: reprogram a running prescaler; the change lands at the next boundary
  task automatic set_ps_run(int p, int d, int cv);
    pD[p] = d; pC[p] = cv; pP[p] = 1'b1; pB[p] = next_boundary(p);
    wr('h08 + 4*p, d & 'hff);
    wr('h09 + 4*p, (d >> 8) & 'hff);
    wr('h0A + 4*p, cv);
  endtask

  task automatic set_duty_run(int c, int v);
    pduty[c] = v; pdP[c] = 1'b1; pdB[c] = next_boundary(msel[c]);
    wr('h20 + c, v);
  endtask

  task automatic run_cycles(int n, int fpat, int spat);
    for (int i = 0; i < n; i++) begin
      bit f, s, lvl, t;
      bit [NCH-1:0] eo, eoe;
      string tag;
      f = (i % fpat) == 0;
      s = (i % spat) == 0;
      for (int c = 0; c < NCH; c++) begin
        lvl = exp_raw(c) ^ mpol[c];
        eo[c] = lvl;
        eoe[c] = mod_[c] ? ~lvl : 1'b1;
      end
      fast_tick = f; slow_tick = s;
      @(posedge clk);
      for (int p = 0; p < NPS; p++) begin
        t = mrun && (msrc[p] ? f : s);  // R2: source per prescaler
        if (t) begin
          mn[p]++;
          if (pP[p] && mn[p] == pB[p]) begin
            mD[p] = pD[p]; mC[p] = pC[p]; mbase[p] = pB[p]; pP[p] = 1'b0;
          end
          for (int c = 0; c < NCH; c++)
            if (msel[c] == p && pdP[c] && mn[p] == pdB[c]) begin
              mduty[c] = pduty[c]; pdP[c] = 1'b0;
            end
        end
      end
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        vectors++;
        if (pwm_out[c] !== eo[c] || pwm_oe[c] !== eoe[c]) begin
          miscompares++;
          if (!mrun) tag = "R8";
          else if (mgate[c]) tag = "R5";
          else if (msel[c] >= NPS) tag = "R3";
          else tag = req;
          $display("FAIL %s ch%0d: out=%b oe=%b expected out=%b oe=%b",
                   tag, c, pwm_out[c], pwm_oe[c], eo[c], eoe[c]);
        end
      end
    end
    fast_tick = 1'b0; slow_tick = 1'b0;
  endtask

  initial begin
    #(190000 * 5);
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int cfg, cv;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    fast_tick = 1'b0; slow_tick = 1'b0;
    mrun = 1'b0;
    for (int p = 0; p < NPS; p++) begin
      mD[p] = 0; mC[p] = 0; pP[p] = 0; msrc[p] = 0; mn[p] = 0; mbase[p] = 0;
    end
    for (int c = 0; c < NCH; c++) begin
      mduty[c] = 0; pdP[c] = 0; msel[c] = 0; mgate[c] = 0; mpol[c] = 0; mod_[c] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    vectors++;
    if (pwm_out !== '0 || pwm_oe !== '1) begin
      miscompares++;
      $display("FAIL R10: out=%b oe=%b expected out=0000 oe=1111", pwm_out, pwm_oe);
    end

    // Sweep: R4 compare, R2 source, R3 selector, R5 gate, R6 polarity, R7 open-drain, R8 run
    cfg = 0;
    for (int ci = 0; ci < 4; ci++)
      for (int d = 0; d < 3; d++)
        for (int j = 0; j < 6; j++) begin
          cv = (ci == 3) ? 5 : ci;
          mD[0] = d;            mC[0] = cv;
          mD[1] = (d + 1) % 3;  mC[1] = (cv + 2) % 7;
          mD[2] = cv % 2;       mC[2] = d + 1;
          for (int p = 0; p < NPS; p++) msrc[p] = ((cfg >> p) & 1) != 0;
          for (int c = 0; c < NCH; c++) begin
            msel[c]  = (c + cfg) % 4;
            mduty[c] = (msel[c] < NPS) ? (j + c) % (mC[msel[c]] + 3) : j;
            mgate[c] = (cfg % 7) == c;
            mpol[c]  = ((cfg + c) % 3) == 0;
            mod_[c]  = ((cfg + c) % 2) == 1;
          end
          set_run(1'b0);
          push_all();
          req = "R8";
          run_cycles(3, 1, 1);  // ticks while stopped are ignored
          set_run(1'b1);
          req = "R4";
          run_cycles(130, 1 + (cfg % 2), 3);
          cfg++;
        end

    // R1: divider above 255 exercises the high byte
    set_run(1'b0);
    msrc[0] = 1'b1; mD[0] = 'h102; mC[0] = 1;
    for (int c = 0; c < NCH; c++) begin
      msel[c] = 0; mgate[c] = 0; mpol[c] = 0; mod_[c] = 0; mduty[c] = c;
    end
    push_all();
    set_run(1'b1);
    req = "R1";
    run_cycles(1100, 1, 1);

    // R9: mid-period reprogramming
    set_run(1'b0);
    mD[0] = 1; mC[0] = 3;
    mduty[0] = 2; mduty[1] = 3; mduty[2] = 1; mduty[3] = 4;
    push_all();
    set_run(1'b1);
    req = "R9";
    run_cycles(13, 1, 1);
    set_ps_run(0, 0, 5);
    set_duty_run(0, 4);
    run_cycles(40, 1, 1);
    set_duty_run(1, 1);
    run_cycles(30, 2, 1);
    set_ps_run(0, 2, 2);
    run_cycles(50, 1, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule